// File: doc/BRIEF.md
# Packed 128-bit SIMD Lane Unit

This block is a purely combinational execution slice for 128-bit packed integer work. It takes two vector operands, an 8-bit immediate, a 32-bit scalar operand and a 4-bit operation code. It produces one 128-bit vector result and one 32-bit scalar result in the same evaluation. A surrounding pipeline registers whichever result the operation defines.

The arithmetic uses a single segmented adder built from sixteen byte slices. The carry between neighbouring slices is cut at byte, word or doubleword edges, according to the lane size the operation selects. The other datapaths sit beside the adder:
- a doubleword permute steered by the immediate,
- a gather of the top bit of every byte into a scalar mask,
- moves of the low doubleword between the scalar and vector domains,
- an extract of one doubleword picked by a scalar index,
- a plain full-width copy.

For each operation, the result port that the operation does not define is driven to zero. The block has no clock and no state, so it has no states or transitions to name. The single selection of the operation code takes the place of a state register.

Top module: `simd_lane_unit`

## Requirements
- R1: With op code 0 (byte add), each of the 16 byte lanes of vec_o equals the sum of the matching bytes of vec_a_i and vec_b_i modulo 256, with no carry into the next byte; scal_o is zero.
- R2: With op code 1 (word add), each of the 8 16-bit lanes of vec_o equals the lane sum modulo 65536, with no carry across word edges; scal_o is zero.
- R3: With op code 2 (doubleword add), each of the 4 32-bit lanes of vec_o equals the lane sum modulo 2^32, with no carry across doubleword edges; scal_o is zero.
- R4: With op code 3 (permute), doubleword lane i of vec_o (bits 32i+31:32i) equals doubleword lane imm_i[2i+1:2i] of vec_b_i, for i from 0 to 3; scal_o is zero.
- R5: With op code 4 (sign mask), scal_o bit i equals vec_a_i bit 8i+7 for i from 0 to 15, scal_o bits 31:16 are zero, and vec_o is zero.
- R6: With op code 5 (scalar to vector), vec_o bits 31:0 equal scal_i and vec_o bits 127:32 are zero; scal_o is zero.
- R7: With op code 6 (vector to scalar), scal_o equals vec_a_i bits 31:0 and vec_o is zero.
- R8: With op code 7 (indexed extract), scal_o equals doubleword lane scal_i[1:0] of vec_a_i; scal_i bits 31:2 have no effect on the result; vec_o is zero.
- R9: With op code 8 (copy), vec_o equals vec_b_i and scal_o is zero.
- R10: With any op code from 9 to 15, both vec_o and scal_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code, values listed in the requirements |
| vec_a_i | input | 128 | First vector operand: add, mask, vector-to-scalar and extract source |
| vec_b_i | input | 128 | Second vector operand: add, permute and copy source |
| imm_i | input | 8 | Permute selector, two bits per output doubleword |
| scal_i | input | 32 | Scalar operand: move source or lane index |
| vec_o | output | 128 | Vector result |
| scal_o | output | 32 | Scalar result |

## Verification
Within one evaluation, two functions of the adder must act at the same edge. A slice can produce a carry out just where the selected lane size requires the carry chain to be cut, so the wrap inside one lane and the cut into the next lane happen together. This is provoked by all-ones, 0x7F/0x80 and 0xFF-plus-one byte patterns, applied under all three lane sizes. Each lane is judged against a per-lane sum reduced modulo its own width. The second coincidence is that both result ports are live on every operation. Each check therefore judges the unused port as zero together with the defined one.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int unsigned VEC_W   = 128;
    localparam int unsigned DW      = 32;
    localparam int unsigned NBYTES  = VEC_W / 8;
    localparam int unsigned NDW     = VEC_W / DW;
    localparam int unsigned IDX_W   = $clog2(NDW);

    typedef enum logic [3:0] {
        OP_ADD_B  = 4'd0,
        OP_ADD_W  = 4'd1,
        OP_ADD_D  = 4'd2,
        OP_PERM   = 4'd3,
        OP_SMASK  = 4'd4,
        OP_S2V    = 4'd5,
        OP_V2S    = 4'd6,
        OP_XTRACT = 4'd7,
        OP_COPY   = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        SEG_BYTE  = 2'd0,
        SEG_WORD  = 2'd1,
        SEG_DWORD = 2'd2
    } seg_e;

endpackage

// File: rtl/simd_seg_adder.sv
module simd_seg_adder
    import simd_pkg::*;
#(
    parameter int unsigned N_BYTES = NBYTES
) (
    input  logic [8*N_BYTES-1:0] a_i,
    input  logic [8*N_BYTES-1:0] b_i,
    input  seg_e                 seg_i,
    output logic [8*N_BYTES-1:0] sum_o
);

    always_comb begin
        logic       c;
        logic       cut;
        logic [8:0] part;
        c = 1'b0;
        for (int i = 0; i < int'(N_BYTES); i++) begin
            unique case (seg_i)
                SEG_BYTE:  cut = 1'b1;
                SEG_WORD:  cut = (i % 2) == 0;
                default:   cut = (i % 4) == 0;
            endcase
            part = {1'b0, a_i[8*i +: 8]} + {1'b0, b_i[8*i +: 8]} + {8'd0, (c & ~cut)};
            sum_o[8*i +: 8] = part[7:0];
            c = part[8];
        end
    end

    always_comb begin
        if (seg_i == SEG_BYTE)
            AST_BYTE_TOP_WRAP: assert (sum_o[8*N_BYTES-1 -: 8] ==
                8'(a_i[8*N_BYTES-1 -: 8] + b_i[8*N_BYTES-1 -: 8])); // R1
        if (seg_i == SEG_WORD)
            AST_WORD_TOP_WRAP: assert (sum_o[8*N_BYTES-1 -: 16] ==
                16'(a_i[8*N_BYTES-1 -: 16] + b_i[8*N_BYTES-1 -: 16])); // R2
        if (seg_i == SEG_DWORD)
            AST_DWORD_LOW_WRAP: assert (sum_o[31:0] == 32'(a_i[31:0] + b_i[31:0])); // R3
    end

endmodule

// File: rtl/simd_dw_permute.sv
module simd_dw_permute
    import simd_pkg::*;
#(
    parameter int unsigned LANES = NDW,
    parameter int unsigned LW    = DW
) (
    input  logic [LANES*LW-1:0]             src_i,
    input  logic [LANES*$clog2(LANES)-1:0]  sel_i,
    output logic [LANES*LW-1:0]             dst_o
);

    localparam int unsigned SW = $clog2(LANES);

    generate
        for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
            logic [SW-1:0] pick;
            assign pick = sel_i[g*SW +: SW];
            assign dst_o[g*LW +: LW] = src_i[pick*LW +: LW];
        end
    endgenerate

    always_comb begin
        for (int k = 0; k < int'(LANES); k++) begin
            if (sel_i[SW-1:0] == SW'(k))
                AST_PERM_LANE0: assert (dst_o[LW-1:0] == src_i[k*LW +: LW]); // R4
        end
    end

endmodule

// File: rtl/simd_sign_gather.sv
module simd_sign_gather
    import simd_pkg::*;
#(
    parameter int unsigned N_BYTES = NBYTES,
    parameter int unsigned OUT_W   = DW
) (
    input  logic [8*N_BYTES-1:0] vec_i,
    output logic [OUT_W-1:0]     mask_o
);

    always_comb begin
        mask_o = '0;
        for (int i = 0; i < int'(N_BYTES); i++)
            mask_o[i] = vec_i[8*i+7];
    end

    always_comb begin
        AST_MASK_HIGH_ZERO: assert (mask_o[OUT_W-1:N_BYTES] == '0); // R5
        AST_MASK_POPCOUNT:  assert ($countones(mask_o) <= int'(N_BYTES)); // R5
    end

endmodule

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
    import simd_pkg::*;
(
    input  logic [3:0]   op_i,
    input  logic [127:0] vec_a_i,
    input  logic [127:0] vec_b_i,
    input  logic [7:0]   imm_i,
    input  logic [31:0]  scal_i,
    output logic [127:0] vec_o,
    output logic [31:0]  scal_o
);

    seg_e              seg;
    logic [VEC_W-1:0]  add_res;
    logic [VEC_W-1:0]  perm_res;
    logic [DW-1:0]     mask_res;
    logic [IDX_W-1:0]  lane_idx;

    always_comb begin
        unique case (op_i)
            OP_ADD_B: seg = SEG_BYTE;
            OP_ADD_W: seg = SEG_WORD;
            default:  seg = SEG_DWORD;
        endcase
    end

    simd_seg_adder #(.N_BYTES(NBYTES)) u_add (
        .a_i   (vec_a_i),
        .b_i   (vec_b_i),
        .seg_i (seg),
        .sum_o (add_res)
    );

    simd_dw_permute #(.LANES(NDW), .LW(DW)) u_perm (
        .src_i (vec_b_i),
        .sel_i (imm_i),
        .dst_o (perm_res)
    );

    simd_sign_gather #(.N_BYTES(NBYTES), .OUT_W(DW)) u_mask (
        .vec_i  (vec_a_i),
        .mask_o (mask_res)
    );

    assign lane_idx = scal_i[IDX_W-1:0];

    always_comb begin
        vec_o  = '0;
        scal_o = '0;
        unique case (op_i)
            OP_ADD_B, OP_ADD_W, OP_ADD_D: vec_o = add_res;
            OP_PERM:   vec_o  = perm_res;
            OP_SMASK:  scal_o = mask_res;
            OP_S2V:    vec_o  = {{(VEC_W-DW){1'b0}}, scal_i};
            OP_V2S:    scal_o = vec_a_i[DW-1:0];
            OP_XTRACT: scal_o = vec_a_i[lane_idx*DW +: DW];
            OP_COPY:   vec_o  = vec_b_i;
            default: begin
                vec_o  = '0;
                scal_o = '0;
            end
        endcase
    end

    always_comb begin
        if (op_i == OP_S2V)
            AST_S2V_UPPER_CLEAR: assert (vec_o[VEC_W-1:DW] == '0 && scal_o == '0); // R6
        if (op_i == OP_V2S)
            AST_V2S_LOW_LANE: assert (scal_o == add_res[DW-1:0] - vec_b_i[DW-1:0]); // R7
        if (op_i == OP_XTRACT && lane_idx == '0)
            AST_XTRACT_LANE0: assert (scal_o == vec_a_i[DW-1:0]); // R8
        if (op_i == OP_COPY)
            AST_COPY_SCAL_ZERO: assert (scal_o == '0 && vec_o == vec_b_i); // R9
        if (op_i > OP_COPY)
            AST_UNUSED_OP_IDLE: assert (vec_o == '0 && scal_o == '0); // R10
        if (op_i == OP_SMASK)
            AST_MASK_VEC_ZERO: assert (vec_o == '0); // R5
    end

endmodule

// File: tb/simd_lane_unit_tb.sv
module simd_lane_unit_tb;

    logic         clk = 1'b0;
    logic [3:0]   op  = 4'd15;
    logic [127:0] va  = '0;
    logic [127:0] vb  = '0;
    logic [7:0]   imm = '0;
    logic [31:0]  sc  = '0;
    logic [127:0] vo;
    logic [31:0]  so;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    simd_lane_unit u_dut (
        .op_i(op), .vec_a_i(va), .vec_b_i(vb), .imm_i(imm), .scal_i(sc),
        .vec_o(vo), .scal_o(so)
    );

    function automatic logic [127:0] pat(int k);
        logic [127:0] r;
        logic [31:0]  s;
        s = 32'(k) * 32'h9E37_79B9 + 32'h1234_5677;
        for (int j = 0; j < 4; j++) begin
            s = s ^ (s << 13);
            s = s ^ (s >> 17);
            s = s ^ (s << 5);
            r[32*j +: 32] = s;
        end
        return r;
    endfunction

    function automatic logic [127:0] lane_add(logic [127:0] a, logic [127:0] b, int bits);
        logic [127:0] r;
        longint unsigned modv, x, y;
        modv = 64'd1 << bits;
        for (int i = 0; i < 128 / bits; i++) begin
            x = 0; y = 0;
            for (int j = 0; j < bits; j++) begin
                x = x | (longint'(a[i*bits + j]) << j);
                y = y | (longint'(b[i*bits + j]) << j);
            end
            x = (x + y) % modv;
            for (int j = 0; j < bits; j++) r[i*bits + j] = x[j];
        end
        return r;
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [3:0] o, logic [127:0] a, logic [127:0] b,
                         logic [7:0] i, logic [31:0] s);
        @(posedge clk);
        op = o; va = a; vb = b; imm = i; sc = s;
        @(negedge clk);
    endtask

    initial begin
        logic [127:0] a, b, e;
        @(negedge clk);
        // R10 initial state with idle code
        chk("R10 idle vec", vo, '0);
        chk("R10 idle scal", {96'd0, so}, '0);

        for (int k = 0; k < 48; k++) begin
            case (k)
                0: begin a = '1; b = 128'd1; end
                1: begin a = {16{8'h7F}}; b = {16{8'h01}}; end
                2: begin a = {16{8'hFF}}; b = {16{8'hFF}}; end
                3: begin a = {8{16'hFFFF}}; b = {8{16'h0001}}; end
                default: begin a = pat(k); b = pat(k + 100); end
            endcase
            apply(4'd0, a, b, 8'h00, 32'h0);
            chk("R1 byte add", vo, lane_add(a, b, 8));
            chk("R1 scal zero", {96'd0, so}, '0);
            apply(4'd1, a, b, 8'h00, 32'h0);
            chk("R2 word add", vo, lane_add(a, b, 16));
            apply(4'd2, a, b, 8'h00, 32'h0);
            chk("R3 dword add", vo, lane_add(a, b, 32));
            chk("R3 scal zero", {96'd0, so}, '0);

            apply(4'd4, a, b, 8'h00, 32'h0);
            e = '0;
            for (int i = 0; i < 16; i++) e[i] = a[8*i+7];
            chk("R5 mask", {96'd0, so}, e);
            chk("R5 vec zero", vo, '0);

            apply(4'd5, a, b, 8'h00, b[63:32]);
            chk("R6 s2v", vo, {96'd0, b[63:32]});
            chk("R6 scal zero", {96'd0, so}, '0);

            apply(4'd6, a, b, 8'h00, 32'hFFFF_FFFF);
            chk("R7 v2s", {96'd0, so}, {96'd0, a[31:0]});
            chk("R7 vec zero", vo, '0);

            for (int ix = 0; ix < 8; ix++) begin
                apply(4'd7, a, b, 8'h00, (32'(k) << 3) | 32'(ix));
                chk("R8 extract", {96'd0, so}, {96'd0, a[32*(ix%4) +: 32]});
            end
            chk("R8 vec zero", vo, '0);

            apply(4'd8, a, b, 8'h00, 32'h0);
            chk("R9 copy", vo, b);
            chk("R9 scal zero", {96'd0, so}, '0);

            for (int oc = 9; oc < 16; oc++) begin
                apply(4'(oc), a, b, 8'hFF, 32'hFFFF_FFFF);
                chk("R10 unused vec", vo, '0);
                chk("R10 unused scal", {96'd0, so}, '0);
            end
        end

        b = pat(7);
        for (int s = 0; s < 256; s++) begin
            apply(4'd3, pat(9), b, 8'(s), 32'h0);
            for (int i = 0; i < 4; i++) e[32*i +: 32] = b[32*((s >> (2*i)) % 4) +: 32];
            chk("R4 permute", vo, e);
            chk("R4 scal zero", {96'd0, so}, '0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule